// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block paces a serial transmitter and receiver. Once a frame is launched, it counts reference steps against a divisor that has an integer part and a binary fraction. It emits one bit tick at the end of every bit period and one half tick in the middle of it. The frame is launched with a one-cycle start strobe, which also carries the number of bit periods in the frame. Once that many bit ticks have been produced, the generator goes quiet until the next start.

The fraction can be honoured in two ways:

- **Uniform mode.** The fraction is rounded once, so every bit of the frame gets the same length.
- **Spread mode.** A fraction accumulator is stepped once per bit. A bit is lengthened by one step whenever the accumulator carries, so the end of the frame lands as close as possible to the ideal instant.

The accumulator restarts at every frame start, so frames with the same settings are identical.

The reference is either the system clock or a single-cycle strobe derived from a slower internal oscillator. The strobe is counted in the system clock domain, so no clock is switched. Dropping the enable holds the count logic still, suppresses every tick and abandons any frame in progress.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and with the block enabled but no frame started, bit_tick and half_tick stay low.
- R2: With the system clock as reference, the first bit_tick is high in the cycle that comes L1 cycles after the clock edge that sampled frame_start, where L1 is the length of bit 1.
- R3: With acc_mode=1 (uniform), every bit lasts I + div_frac[FRAC_W-1] reference steps, where I is the effective integer divisor.
- R4: With acc_mode=0 (spread), bit k (counting from 1) lasts I + floor(k*F/2^FRAC_W) - floor((k-1)*F/2^FRAC_W) steps, where F is div_frac. A frame of N bits therefore lasts N*I + floor(N*F/2^FRAC_W) steps.
- R5: The fraction accumulator is zero at every frame start, so consecutive frames with the same settings have identical bit lengths.
- R6: An integer divisor of 0 or 1 is used as 2, so no bit is shorter than 2 steps.
- R7: half_tick pulses once per bit, floor(L/2) steps after the bit begins (L is that bit's length), and it is never high together with bit_tick.
- R8: A frame yields exactly frame_bits bit ticks and then none until the next start. A start with frame_bits=0 yields none.
- R9: With ref_sel=1, counting advances only on cycles where alt_ref_tick is high. With a periodic strobe of period P, consecutive bit ticks are L*P cycles apart.
- R10: While enable is low, no tick is produced from the following cycle onward, the running frame is abandoned, and frame_start is ignored. Raising enable again does not resume the abandoned frame.
- R11: A frame_start during a running frame restarts timing from bit 1, with the accumulator cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Generator enable; low gates all counting |
| ref_sel | input | 1 | Reference select: 0 system clock, 1 alternate strobe |
| alt_ref_tick | input | 1 | One-cycle strobe from the alternate oscillator |
| div_int | input | INT_W | Integer part of the divisor in reference steps |
| div_frac | input | FRAC_W | Fractional part of the divisor, in units of 2^-FRAC_W |
| acc_mode | input | 1 | 1 uniform bit lengths, 0 fraction spread over the frame |
| frame_start | input | 1 | One-cycle strobe that launches (or relaunches) a frame |
| frame_bits | input | LEN_W | Number of bit periods in the frame, sampled with frame_start |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| half_tick | output | 1 | One-cycle pulse at the midpoint of each bit period |

## Verification
A corrupted fraction accumulator is not visible in the first bit. It first shows at the first bit whose carry it changes: that bit_tick arrives one cycle early or late, which happens within 2^FRAC_W / div_frac bits of the start. A corrupted step counter moves the very first half_tick or bit_tick away from its computed cycle. A corrupted remaining-bit count shows as a missing or extra bit_tick about one bit period after the last expected one. Random divisors, fractions, modes and frame lengths are mixed with directed cases for clamping, an empty frame, a mid-frame restart, disabling and the strobed reference.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

   // How the divisor fraction is honoured within a frame.
   typedef enum logic {
      ACC_SPREAD  = 1'b0,
      ACC_UNIFORM = 1'b1
   } acc_mode_e;

   // Smallest bit length the counter can time.
   localparam int unsigned MIN_BIT_LEN = 2;

endpackage

// File: rtl/baud_ref_step.sv
module baud_ref_step #(
   parameter bit HAS_ALT_REF = 1'b1
) (
   input  logic enable,
   input  logic ref_sel,
   input  logic alt_ref_tick,
   output logic step
);

   generate
      if (HAS_ALT_REF) begin : g_alt
         // One count per alternate strobe, or one per system cycle.
         assign step = enable & (ref_sel ? alt_ref_tick : 1'b1);
      end else begin : g_sys
         // Alternate reference not built: select and strobe are ignored.
         logic unused_ref;
         assign unused_ref = ref_sel ^ alt_ref_tick;
         assign step = enable;
      end
   endgenerate

endmodule

// File: rtl/baud_len_calc.sv
module baud_len_calc
   import baud_tick_pkg::*;
#(
   parameter int unsigned INT_W  = 12,
   parameter int unsigned FRAC_W = 4
) (
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  acc_mode_e         mode,
   input  logic [FRAC_W-1:0] acc_q,
   output logic [INT_W:0]    bit_len,
   output logic [FRAC_W-1:0] acc_next
);

   localparam logic [INT_W-1:0] INT_FLOOR = INT_W'(MIN_BIT_LEN);

   logic [INT_W-1:0] int_eff;
   logic [FRAC_W:0]  frac_sum;
   logic             stretch;

   assign int_eff  = (div_int < INT_FLOOR) ? INT_FLOOR : div_int;
   assign frac_sum = {1'b0, acc_q} + {1'b0, div_frac};

   always_comb begin
      if (mode == ACC_UNIFORM) begin
         // Round to nearest once: the top fraction bit is the half point.
         stretch  = div_frac[FRAC_W-1];
         acc_next = '0;
      end else begin
         // Carry out of the accumulator lengthens this bit by one step.
         stretch  = frac_sum[FRAC_W];
         acc_next = frac_sum[FRAC_W-1:0];
      end
      bit_len = {1'b0, int_eff} + {{INT_W{1'b0}}, stretch};
   end

   // R6: the length handed to the counter never drops below two steps
   always_comb begin
      p_len_floor_r6: assert (bit_len >= (INT_W+1)'(MIN_BIT_LEN));
   end

endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
   parameter int unsigned FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [FRAC_W-1:0] acc_next,
   output logic [FRAC_W-1:0] acc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear) begin
         acc_q <= '0;
      end else if (advance) begin
         acc_q <= acc_next;
      end
   end

   // R5 / R11: a frame (re)start leaves the accumulator empty
   p_acc_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0));

endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
   parameter int unsigned INT_W = 12,
   parameter int unsigned LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             step,
   input  logic             start,
   input  logic [LEN_W-1:0] frame_bits,
   input  logic [INT_W:0]   bit_len,
   output logic             bit_end,
   output logic             bit_tick,
   output logic             half_tick
);

   localparam logic [LEN_W-1:0] LAST_BIT = LEN_W'(1);

   logic             active;
   logic [INT_W:0]   cnt;
   logic [LEN_W-1:0] bits_left;
   logic [INT_W:0]   half_pt;
   logic             at_half;

   assign half_pt = bit_len >> 1;
   assign bit_end = active & step & (cnt >= (bit_len - 1'b1));
   assign at_half = active & step & (cnt == (half_pt - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         cnt       <= '0;
         bits_left <= '0;
         bit_tick  <= 1'b0;
         half_tick <= 1'b0;
      end else if (!enable) begin
         active    <= 1'b0;
         cnt       <= '0;
         bits_left <= '0;
         bit_tick  <= 1'b0;
         half_tick <= 1'b0;
      end else if (start) begin
         active    <= (frame_bits != '0);
         cnt       <= '0;
         bits_left <= frame_bits;
         bit_tick  <= 1'b0;
         half_tick <= 1'b0;
      end else begin
         bit_tick  <= bit_end;
         half_tick <= at_half;
         if (bit_end) begin
            cnt       <= '0;
            bits_left <= bits_left - 1'b1;
            if (bits_left == LAST_BIT) begin
               active <= 1'b0;
            end
         end else if (active && step) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R7: the midpoint and the end of a bit never share a cycle
   p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> !half_tick);

   // R10: a low enable silences both ticks on the next cycle
   p_gated_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!bit_tick && !half_tick));

   // R8: once the frame has run out, no further bit tick appears
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !bit_tick);

   // R11: an accepted start rewinds the step count
   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && enable) |=> (cnt == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_tick_pkg::*;
#(
   parameter int unsigned INT_W       = 12,
   parameter int unsigned FRAC_W      = 4,
   parameter int unsigned LEN_W       = 4,
   parameter bit          HAS_ALT_REF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              ref_sel,
   input  logic              alt_ref_tick,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   input  logic              acc_mode,
   input  logic              frame_start,
   input  logic [LEN_W-1:0]  frame_bits,
   output logic              bit_tick,
   output logic              half_tick
);

   // Elaboration-time parameter checks
   generate
      if (INT_W < 2) begin : g_bad_int_w
         $error("baud_tick_gen: INT_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac_w
         $error("baud_tick_gen: FRAC_W must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len_w
         $error("baud_tick_gen: LEN_W must be at least 1");
      end
   endgenerate

   logic              step;
   logic              bit_end;
   logic              acc_clear;
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W-1:0] acc_next;
   logic [INT_W:0]    bit_len;
   acc_mode_e         mode;

   assign mode      = acc_mode_e'(acc_mode);
   assign acc_clear = frame_start | ~enable;

   baud_ref_step #(
      .HAS_ALT_REF (HAS_ALT_REF)
   ) u_step (
      .enable       (enable),
      .ref_sel      (ref_sel),
      .alt_ref_tick (alt_ref_tick),
      .step         (step)
   );

   baud_len_calc #(
      .INT_W  (INT_W),
      .FRAC_W (FRAC_W)
   ) u_len (
      .div_int  (div_int),
      .div_frac (div_frac),
      .mode     (mode),
      .acc_q    (acc_q),
      .bit_len  (bit_len),
      .acc_next (acc_next)
   );

   baud_frac_acc #(
      .FRAC_W (FRAC_W)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (acc_clear),
      .advance  (bit_end),
      .acc_next (acc_next),
      .acc_q    (acc_q)
   );

   baud_bit_counter #(
      .INT_W (INT_W),
      .LEN_W (LEN_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .step       (step),
      .start      (frame_start),
      .frame_bits (frame_bits),
      .bit_len    (bit_len),
      .bit_end    (bit_end),
      .bit_tick   (bit_tick),
      .half_tick  (half_tick)
   );

   // R9: with the strobed reference selected, a bit cannot end without a strobe
   p_strobe_paced_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_ALT_REF && ref_sel && !alt_ref_tick) |-> !bit_end);

endmodule

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;

   localparam int INT_W  = 12;
   localparam int FRAC_W = 4;
   localparam int LEN_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              enable;
   logic              ref_sel;
   logic              alt_ref_tick;
   logic [INT_W-1:0]  div_int;
   logic [FRAC_W-1:0] div_frac;
   logic              acc_mode;
   logic              frame_start;
   logic [LEN_W-1:0]  frame_bits;
   logic              bit_tick;
   logic              half_tick;

   int checks   = 0;
   int failures = 0;
   int alt_p    = 0;
   int alt_c    = 0;

   always #2 clk = ~clk;

   baud_tick_gen #(
      .INT_W  (INT_W),
      .FRAC_W (FRAC_W),
      .LEN_W  (LEN_W)
   ) i_baud_tick_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .ref_sel      (ref_sel),
      .alt_ref_tick (alt_ref_tick),
      .div_int      (div_int),
      .div_frac     (div_frac),
      .acc_mode     (acc_mode),
      .frame_start  (frame_start),
      .frame_bits   (frame_bits),
      .bit_tick     (bit_tick),
      .half_tick    (half_tick)
   );

   // Periodic alternate-reference strobe, driven away from the active edge
   always @(negedge clk) begin
      if (alt_p > 0) begin
         alt_ref_tick = (alt_c == 0);
         alt_c = (alt_c + 1 >= alt_p) ? 0 : alt_c + 1;
      end else begin
         alt_ref_tick = 1'b0;
      end
   end

   // Expected length of bit k (from 1), from R3, R4 and R6
   function automatic int exp_len(int idiv, int f, bit uniform, int k);
      int ie;
      ie = (idiv < 2) ? 2 : idiv;
      if (uniform) return ie + ((f >= (1 << (FRAC_W-1))) ? 1 : 0);
      return ie + ((k * f) >> FRAC_W) - (((k - 1) * f) >> FRAC_W);
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic configure(int idiv, int f, bit uniform, int n, bit rsel);
      @(negedge clk);
      div_int    = INT_W'(idiv);
      div_frac   = FRAC_W'(f);
      acc_mode   = uniform;
      frame_bits = LEN_W'(n);
      ref_sel    = rsel;
   endtask

   // Leaves the bench at the first negedge after the sampling edge (k = 0)
   task automatic pulse_start();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic count_quiet(int cycles, string req, string what);
      int seen;
      seen = 0;
      for (int k = 0; k < cycles; k++) begin
         if (bit_tick || half_tick) seen++;
         @(negedge clk);
      end
      check(seen == 0, req, what, seen, 0);
   endtask

   task automatic observe(int idiv, int f, bit uniform, int n, int p, string req);
      int bt[32];
      int ht[32];
      int nb, nh, total, limit, cum, len, lim_n;
      nb = 0; nh = 0; total = 0; cum = 0;
      for (int k = 1; k <= n; k++) total += exp_len(idiv, f, uniform, k);
      limit = (total + 3) * ((p > 0) ? p : 1) + 4;
      for (int k = 0; k <= limit; k++) begin
         if (bit_tick) begin
            if (nb < 32) bt[nb] = k;
            nb++;
         end
         if (half_tick) begin
            if (nh < 32) ht[nh] = k;
            nh++;
         end
         if (bit_tick && half_tick) check(1'b0, "R7", "ticks coincide at step", k, -1);
         @(negedge clk);
      end
      check(nb == n, "R8", "bit tick count", nb, n);
      check(nh == n, "R7", "half tick count", nh, n);
      lim_n = (nb < n) ? nb : n;
      if (lim_n > 32) lim_n = 32;
      if (p == 0) begin
         for (int i = 0; i < lim_n; i++) begin
            len = exp_len(idiv, f, uniform, i + 1);
            if (i < nh) check(ht[i] == cum + len / 2, "R7", "half tick cycle", ht[i], cum + len / 2);
            cum += len;
            if (i == 0) check(bt[0] == cum, "R2", "first bit tick cycle", bt[0], cum);
            check(bt[i] == cum, req, "bit tick cycle", bt[i], cum);
         end
      end else begin
         for (int i = 1; i < lim_n; i++) begin
            len = exp_len(idiv, f, uniform, i + 1) * p;
            check(bt[i] - bt[i-1] == len, req, "strobed bit spacing", bt[i] - bt[i-1], len);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R8 run hung actual=200000 expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; enable = 1'b0; ref_sel = 1'b0;
      div_int = '0; div_frac = '0; acc_mode = 1'b0;
      frame_start = 1'b0; frame_bits = '0;
      repeat (3) @(negedge clk);
      check(!bit_tick && !half_tick, "R1", "ticks in reset", {bit_tick, half_tick}, 0);
      rst_n = 1'b1;
      enable = 1'b1;
      @(negedge clk);
      count_quiet(20, "R1", "ticks without a frame");

      // R3 uniform: 5 + round(8/16) = 6, and 5 + round(7/16) = 5
      configure(5, 8, 1'b1, 10, 1'b0); pulse_start(); observe(5, 8, 1'b1, 10, 0, "R3");
      configure(5, 7, 1'b1, 7, 1'b0);  pulse_start(); observe(5, 7, 1'b1, 7, 0, "R3");

      // R4 spread, repeated for R5
      configure(4, 5, 1'b0, 12, 1'b0); pulse_start(); observe(4, 5, 1'b0, 12, 0, "R4");
      pulse_start(); observe(4, 5, 1'b0, 12, 0, "R5");
      configure(3, 15, 1'b0, 15, 1'b0); pulse_start(); observe(3, 15, 1'b0, 15, 0, "R4");

      // R6 clamp
      configure(0, 3, 1'b0, 9, 1'b0);  pulse_start(); observe(0, 3, 1'b0, 9, 0, "R6");
      configure(1, 12, 1'b1, 5, 1'b0); pulse_start(); observe(1, 12, 1'b1, 5, 0, "R6");

      // R8 empty frame
      configure(4, 0, 1'b0, 0, 1'b0); pulse_start(); observe(4, 0, 1'b0, 0, 0, "R8");

      // R9 strobed reference, period 3
      alt_p = 3;
      configure(3, 6, 1'b0, 6, 1'b1); pulse_start(); observe(3, 6, 1'b0, 6, 3, "R9");
      alt_p = 0;
      configure(3, 6, 1'b0, 6, 1'b0);

      // R11 restart in the middle of bit 2
      configure(6, 9, 1'b0, 8, 1'b0); pulse_start();
      repeat (9) @(negedge clk);
      pulse_start(); observe(6, 9, 1'b0, 8, 0, "R11");

      // R10 disable mid-frame, start while disabled, no resumption
      configure(5, 4, 1'b0, 10, 1'b0); pulse_start();
      repeat (12) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      count_quiet(40, "R10", "ticks while disabled");
      pulse_start();
      count_quiet(20, "R10", "ticks after start while disabled");
      enable = 1'b1;
      @(negedge clk);
      count_quiet(80, "R10", "ticks after re-enable");
      pulse_start(); observe(5, 4, 1'b0, 10, 0, "R10");

      // Random frames
      for (int r = 0; r < 30; r++) begin
         int idiv, f, n;
         bit um;
         idiv = $urandom_range(0, 12);
         f    = $urandom_range(0, 15);
         um   = 1'($urandom_range(0, 1));
         n    = $urandom_range(1, 12);
         configure(idiv, f, um, n, 1'b0);
         pulse_start();
         observe(idiv, f, um, n, 0, um ? "R3" : "R4");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule